// File: doc/BRIEF.md
# I2C Controller FIFO and Interrupt Front End

This block is the register-facing half of an I2C controller. It owns two word FIFOs: a transmit FIFO filled by register writes and drained by the packet engine, and a receive FIFO filled by the packet engine and drained by register reads. It also reports how full each FIFO is, flushes either FIFO on command, and collects interrupt causes into a status register that software clears by writing ones. A mask register selects which causes drive the single interrupt line.

Two of the interrupt causes are level conditions. Each compares a FIFO's occupancy with a programmable trigger level, so software can be told when there is room to refill the transmit FIFO or data to collect from the receive FIFO. The other six causes are sticky. Four of them come from the bus engine: no-ack, lost arbitration, packet done and all packets done. The other two come from misuse of the FIFOs by software: a write to a full transmit FIFO and a read from an empty receive FIFO.

Top module: `i2c_fifo_irq_unit`

## Requirements
- R1: After reset, the mask register reads 0, every sticky status bit is 0, the FIFO status register reads 0x80 (both FIFOs empty) and `irq` is low.
- R2: The FIFO status register (address 1) holds the number of free transmit slots in bits 7:4 and the number of stored receive words in bits 3:0. `eng_tx_avail` is high whenever the transmit FIFO holds a word.
- R3: A write to the transmit data register (address 4) while the transmit FIFO already holds 8 words is dropped. It sets status bit 5 and leaves the FIFO contents and their order unchanged.
- R4: A read-pop (reg_re at address 5) from an empty receive FIFO returns 0 and sets status bit 4. An engine push into a full receive FIFO is dropped, and `eng_rx_room` is low while the FIFO is full.
- R5: Writing 1 to control bit 1 flushes the transmit FIFO and writing 1 to control bit 0 flushes the receive FIFO. Each bit reads back 1 in the cycle after the write. By the second clock edge after the write, the bit reads 0 and the FIFO is empty.
- R6: The control register (address 0) holds the transmit trigger level in bits 7:5 and the receive trigger level in bits 4:2. Both read back as written.
- R7: Status bit 1 (transmit request) is high while the number of free transmit slots is at least the transmit trigger level. Status bit 0 (receive request) is high while the number of stored receive words is greater than the receive trigger level.
- R8: The engine events set sticky status bits: packet done sets bit 7, all packets done sets bit 6, no-ack sets bit 3 and arbitration lost sets bit 2. Each bit is visible the cycle after its event.
- R9: Writing 1 to a sticky status bit (address 3) clears it. An event in the same cycle wins over the clear. Writes to the level bits 1:0 have no effect on them.
- R10: `irq` is the OR of all status bits whose mask bit (address 2) is 1.
- R11: Both FIFOs return words in the order they were written. `eng_tx_data` shows the oldest transmit word, or 0 when the transmit FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select: 0 control, 1 FIFO status, 2 mask, 3 status, 4 transmit data, 5 receive data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Read strobe; at address 5 it pops the receive FIFO |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit word |
| eng_tx_data | output | DATA_W | Oldest transmit word |
| eng_tx_avail | output | 1 | Transmit FIFO not empty |
| eng_rx_push | input | 1 | Engine stores a received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_rx_room | output | 1 | Receive FIFO not full |
| ev_nack | input | 1 | No-ack event pulse |
| ev_arb_lost | input | 1 | Arbitration-lost event pulse |
| ev_pkt_done | input | 1 | Packet-done event pulse |
| ev_all_done | input | 1 | All-packets-done event pulse |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, FIFO pushes and pops, and event pulses all take effect on the next clock edge. Sticky status bits and `irq` therefore change one cycle after their cause. The level bits 1:0 follow the FIFO counts in that same cycle, with no extra delay. Read data is combinational, so a register is visible as soon as its address is driven. A flush shows its bit after the first edge and an empty FIFO after the second. The bench applies stimulus after the falling edge and lets the rising edge consume it. At the next falling edge it compares every output with a queue-based model that has been advanced by the same edge. The directed checks peek at registers between edges, so that each one samples exactly the cycle in which its result is due.

// File: rtl/i2cfi_pkg.sv
package i2cfi_pkg;

  localparam int FIELD_W = 4;
  localparam int TRIG_W  = 3;
  localparam int IRQ_W   = 8;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_FSTAT = 3'd1,
    SEL_MASK  = 3'd2,
    SEL_ISTAT = 3'd3,
    SEL_TXD   = 3'd4,
    SEL_RXD   = 3'd5
  } reg_sel_e;

  // control field positions
  localparam int CB_RXFLUSH = 0;
  localparam int CB_TXFLUSH = 1;
  localparam int CB_RXTRIG  = 2;
  localparam int CB_TXTRIG  = 5;

  // status bit positions
  localparam int SB_RXREQ = 0;
  localparam int SB_TXREQ = 1;
  localparam int SB_ARB   = 2;
  localparam int SB_NACK  = 3;
  localparam int SB_RXUDF = 4;
  localparam int SB_TXOVF = 5;
  localparam int SB_ALL   = 6;
  localparam int SB_PKT   = 7;

  function automatic logic [FIELD_W-1:0] slots_free(input logic [FIELD_W-1:0] depth,
                                                    input logic [FIELD_W-1:0] used);
    return depth - used;
  endfunction

  function automatic logic tx_wants(input logic [FIELD_W-1:0] free_n,
                                    input logic [TRIG_W-1:0] trig);
    return free_n >= FIELD_W'(trig);
  endfunction

  function automatic logic rx_wants(input logic [FIELD_W-1:0] used,
                                    input logic [TRIG_W-1:0] trig);
    return used > FIELD_W'(trig);
  endfunction

endpackage

// File: rtl/i2cfi_fifo.sv
module i2cfi_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && !clr && (count != CW'(DEPTH));
  assign do_pop  = pop  && !clr && (count != '0);
  assign rdata   = (count == '0) ? '0 : mem[rp];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= ptr_inc(wp);
      if (do_pop)  rp <= ptr_inc(rp);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/i2cfi_irq.sv
module i2cfi_irq
  import i2cfi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:2] sticky_set,
  input  logic [1:0]       level,
  input  logic             w1c_we,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] wdata,
  output logic [IRQ_W-1:0] status,
  output logic [IRQ_W-1:0] mask,
  output logic             irq
);

  logic [IRQ_W-1:2] sticky_q;
  logic [IRQ_W-1:2] clr_bits;

  assign clr_bits = w1c_we ? wdata[IRQ_W-1:2] : '0;
  assign status   = {sticky_q, level};
  assign irq      = |(status & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      mask     <= '0;
    end else begin
      sticky_q <= (sticky_q & ~clr_bits) | sticky_set;
      if (mask_we) mask <= wdata;
    end
  end

endmodule

// File: rtl/i2c_fifo_irq_unit.sv
module i2c_fifo_irq_unit
  import i2cfi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_tx_pop,
  output logic [DATA_W-1:0] eng_tx_data,
  output logic              eng_tx_avail,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic              eng_rx_room,
  input  logic              ev_nack,
  input  logic              ev_arb_lost,
  input  logic              ev_pkt_done,
  input  logic              ev_all_done,
  output logic              irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  reg_sel_e          sel;
  logic              ctrl_we, mask_we, w1c_we, tx_wr, rx_rd;
  logic [1:0]        flush_q;
  logic [TRIG_W-1:0] tx_trig_q, rx_trig_q;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic [DATA_W-1:0] rx_head;
  logic [FIELD_W-1:0] tx_free, rx_used;
  logic              tx_ovf_evt, rx_udf_evt;
  logic [IRQ_W-1:2]  sticky_set;
  logic [1:0]        level;
  logic [IRQ_W-1:0]  status, mask;

  assign sel     = reg_sel_e'(reg_addr);
  assign ctrl_we = reg_we && (sel == SEL_CTRL);
  assign mask_we = reg_we && (sel == SEL_MASK);
  assign w1c_we  = reg_we && (sel == SEL_ISTAT);
  assign tx_wr   = reg_we && (sel == SEL_TXD);
  assign rx_rd   = reg_re && (sel == SEL_RXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q   <= '0;
      tx_trig_q <= '0;
      rx_trig_q <= '0;
    end else begin
      flush_q <= ctrl_we ? reg_wdata[CB_TXFLUSH:CB_RXFLUSH] : 2'b00;
      if (ctrl_we) begin
        tx_trig_q <= reg_wdata[CB_TXTRIG +: TRIG_W];
        rx_trig_q <= reg_wdata[CB_RXTRIG +: TRIG_W];
      end
    end
  end

  i2cfi_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .clr(flush_q[CB_TXFLUSH]),
    .push(tx_wr), .wdata(reg_wdata),
    .pop(eng_tx_pop), .rdata(eng_tx_data), .count(tx_cnt)
  );

  i2cfi_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .clr(flush_q[CB_RXFLUSH]),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(rx_rd), .rdata(rx_head), .count(rx_cnt)
  );

  assign tx_free      = slots_free(FIELD_W'(DEPTH), FIELD_W'(tx_cnt));
  assign rx_used      = FIELD_W'(rx_cnt);
  assign eng_tx_avail = (tx_cnt != '0);
  assign eng_rx_room  = (rx_cnt != CNT_W'(DEPTH));
  assign tx_ovf_evt   = tx_wr && (tx_cnt == CNT_W'(DEPTH));
  assign rx_udf_evt   = rx_rd && (rx_cnt == '0);

  always_comb begin
    sticky_set           = '0;
    sticky_set[SB_PKT]   = ev_pkt_done;
    sticky_set[SB_ALL]   = ev_all_done;
    sticky_set[SB_TXOVF] = tx_ovf_evt;
    sticky_set[SB_RXUDF] = rx_udf_evt;
    sticky_set[SB_NACK]  = ev_nack;
    sticky_set[SB_ARB]   = ev_arb_lost;
    level[SB_TXREQ]      = tx_wants(tx_free, tx_trig_q);
    level[SB_RXREQ]      = rx_wants(rx_used, rx_trig_q);
  end

  i2cfi_irq u_irq (
    .clk(clk), .rst_n(rst_n), .sticky_set(sticky_set), .level(level),
    .w1c_we(w1c_we), .mask_we(mask_we), .wdata(reg_wdata[IRQ_W-1:0]),
    .status(status), .mask(mask), .irq(irq)
  );

  always_comb begin
    case (sel)
      SEL_CTRL:  reg_rdata = DATA_W'({tx_trig_q, rx_trig_q, flush_q});
      SEL_FSTAT: reg_rdata = DATA_W'({tx_free, rx_used});
      SEL_MASK:  reg_rdata = DATA_W'(mask);
      SEL_ISTAT: reg_rdata = DATA_W'(status);
      SEL_RXD:   reg_rdata = rx_head;
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/i2cfi_checker.sv
module i2cfi_checker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       flush_q,
  input logic             tx_wr,
  input logic             rx_rd,
  input logic             w1c_we,
  input logic [7:0]       wbyte,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [7:0]       status,
  input logic [7:0]       mask,
  input logic             irq
);

  // R3: full transmit FIFO write flags overflow on the next cycle
  p_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_cnt == CNT_W'(DEPTH)) |=> status[5]);

  // R4: empty receive FIFO pop flags underflow on the next cycle
  p_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_cnt == '0) |=> status[4]);

  // R5: pending flush leaves the FIFO empty after the next edge
  p_tx_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q[1] |=> (tx_cnt == '0));

  p_rx_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q[0] |=> (rx_cnt == '0));

  // R7: an empty transmit FIFO always requests data; empty receive never does
  p_tx_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == '0) |-> status[1]);

  p_rx_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0) |-> !status[0]);

  // R9: a sticky bit survives any cycle without a clear of that bit
  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !(w1c_we && wbyte[5])) |=> status[5]);

  // R10: nothing enabled, nothing raised
  p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 8'h00) |-> !irq);

endmodule

bind i2c_fifo_irq_unit i2cfi_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_q(flush_q), .tx_wr(tx_wr), .rx_rd(rx_rd),
  .w1c_we(w1c_we), .wbyte(reg_wdata[7:0]), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .status(status), .mask(mask), .irq(irq)
);

// File: tb/i2c_fifo_irq_unit_bench.sv
module i2c_fifo_irq_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        eng_tx_pop = 1'b0;
  logic [31:0] eng_tx_data;
  logic        eng_tx_avail;
  logic        eng_rx_push = 1'b0;
  logic [31:0] eng_rx_data = '0;
  logic        eng_rx_room;
  logic        ev_nack = 1'b0, ev_arb_lost = 1'b0, ev_pkt_done = 1'b0, ev_all_done = 1'b0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_fifo_irq_unit u_i2c_fifo_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_tx_pop(eng_tx_pop),
    .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_rx_room(eng_rx_room), .ev_nack(ev_nack),
    .ev_arb_lost(ev_arb_lost), .ev_pkt_done(ev_pkt_done), .ev_all_done(ev_all_done),
    .irq(irq)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_txq[$];
  logic [31:0] m_rxq[$];
  logic [2:0]  m_ttrig, m_rtrig;
  logic [1:0]  m_flush;
  logic [7:0]  m_mask;
  logic [7:2]  m_sticky;

  function automatic logic [7:0] exp_status();
    int fr = 8 - m_txq.size();
    return {m_sticky, fr >= int'(m_ttrig), m_rxq.size() > int'(m_rtrig)};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {24'd0, m_ttrig, m_rtrig, m_flush};
      3'd1: return {24'd0, 4'(8 - m_txq.size()), 4'(m_rxq.size())};
      3'd2: return {24'd0, m_mask};
      3'd3: return {24'd0, exp_status()};
      3'd5: return (m_rxq.size() != 0) ? m_rxq[0] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R5";
      3'd1: return "R2";
      3'd2: return "R1";
      3'd3: return "R9";
      3'd5: return "R4";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_txq.delete(); m_rxq.delete();
      m_ttrig = 0; m_rtrig = 0; m_flush = 0; m_mask = 0; m_sticky = 0;
    end else begin
      bit ovf, udf;
      int n;
      ovf = reg_we && reg_addr == 3'd4 && m_txq.size() == 8;
      udf = reg_re && reg_addr == 3'd5 && m_rxq.size() == 0;
      if (m_flush[1]) m_txq.delete();
      else begin
        n = m_txq.size();
        if (eng_tx_pop && n > 0) void'(m_txq.pop_front());
        if (reg_we && reg_addr == 3'd4 && n < 8) m_txq.push_back(reg_wdata);
      end
      if (m_flush[0]) m_rxq.delete();
      else begin
        n = m_rxq.size();
        if (reg_re && reg_addr == 3'd5 && n > 0) void'(m_rxq.pop_front());
        if (eng_rx_push && n < 8) m_rxq.push_back(eng_rx_data);
      end
      m_flush = (reg_we && reg_addr == 3'd0) ? reg_wdata[1:0] : 2'b00;
      if (reg_we && reg_addr == 3'd0) begin
        m_ttrig = reg_wdata[7:5];
        m_rtrig = reg_wdata[4:2];
      end
      if (reg_we && reg_addr == 3'd2) m_mask = reg_wdata[7:0];
      if (reg_we && reg_addr == 3'd3) m_sticky = m_sticky & ~reg_wdata[7:2];
      m_sticky = m_sticky | {ev_pkt_done, ev_all_done, ovf, udf, ev_nack, ev_arb_lost};
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(tag_of(reg_addr), reg_rdata, exp_rd(reg_addr));
    chk("R11", eng_tx_data, (m_txq.size() != 0) ? m_txq[0] : 32'd0);
    chk("R2", {31'd0, eng_tx_avail}, {31'd0, m_txq.size() != 0});
    chk("R4", {31'd0, eng_rx_room}, {31'd0, m_rxq.size() < 8});
    chk("R10", {31'd0, irq}, {31'd0, |(exp_status() & m_mask)});
  endtask

  task automatic idle();
    reg_we = 0; reg_re = 0; eng_tx_pop = 0; eng_rx_push = 0;
    ev_nack = 0; ev_arb_lost = 0; ev_pkt_done = 0; ev_all_done = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1; step(); idle();
  endtask

  task automatic rd(input logic [2:0] a);
    reg_addr = a; reg_re = 1; step(); idle();
  endtask

  task automatic rxpush(input logic [31:0] d);
    eng_rx_data = d; eng_rx_push = 1; step(); idle();
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; reg_we = 0; reg_re = 0;
    #1 v = reg_rdata;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    peek(3'd2, v); chk("R1 mask", v, 32'h0);
    peek(3'd3, v); chk("R1 status", v, 32'h02);
    peek(3'd1, v); chk("R1 fifo status", v, 32'h80);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R6 trigger fields: tx trig 5, rx trig 2
    wr(3'd0, 32'hA8);
    peek(3'd0, v); chk("R6 ctrl", v, 32'hA8);

    for (int i = 0; i < 3; i++) wr(3'd4, 32'h1000 + i);
    peek(3'd1, v); chk("R2 fifo status", v, 32'h50);
    peek(3'd3, v); chk("R7 tx req at free==trig", v & 32'h3, 32'h2);
    wr(3'd4, 32'h1003);
    peek(3'd3, v); chk("R7 tx req below trig", v & 32'h3, 32'h0);
    for (int i = 4; i < 8; i++) wr(3'd4, 32'h1000 + i);
    peek(3'd1, v); chk("R2 tx full", v, 32'h00);
    wr(3'd4, 32'hDEAD);
    peek(3'd3, v); chk("R3 overflow bit", v & 32'h20, 32'h20);
    chk("R3 head unchanged", eng_tx_data, 32'h1000);
    eng_tx_pop = 1; step(); idle();
    chk("R11 tx order", eng_tx_data, 32'h1001);

    // R5 transmit flush
    wr(3'd0, 32'hAA);
    peek(3'd0, v); chk("R5 flush pending", v, 32'hAA);
    step();
    peek(3'd0, v); chk("R5 flush cleared", v, 32'hA8);
    peek(3'd1, v); chk("R5 tx empty", v, 32'h80);

    // R4 underflow
    peek(3'd5, v); chk("R4 empty read", v, 32'h0);
    rd(3'd5);
    peek(3'd3, v); chk("R4 underflow bit", v & 32'h10, 32'h10);

    // R7 receive request and R11 order
    rxpush(32'hA0); rxpush(32'hA1);
    peek(3'd3, v); chk("R7 rx req at trig", v & 32'h1, 32'h0);
    rxpush(32'hA2);
    peek(3'd3, v); chk("R7 rx req above trig", v & 32'h1, 32'h1);
    peek(3'd5, v); chk("R11 rx head", v, 32'hA0);
    rd(3'd5);
    peek(3'd5, v); chk("R11 rx next", v, 32'hA1);

    // R5 receive flush
    wr(3'd0, 32'hA9);
    step();
    peek(3'd1, v); chk("R5 rx empty", v, 32'h80);

    // R8 engine events
    ev_nack = 1; ev_arb_lost = 1; ev_pkt_done = 1; ev_all_done = 1; step(); idle();
    peek(3'd3, v); chk("R8 event bits", v & 32'hCC, 32'hCC);

    // R9 write-one-to-clear, level bits untouched
    wr(3'd3, 32'hFF);
    peek(3'd3, v); chk("R9 cleared", v, 32'h02);

    // R10 masked interrupt
    wr(3'd2, 32'h08);
    chk("R10 irq quiet", {31'd0, irq}, 32'd0);
    ev_nack = 1; step(); idle();
    chk("R10 irq raised", {31'd0, irq}, 32'd1);
    wr(3'd3, 32'h08);
    chk("R10 irq dropped", {31'd0, irq}, 32'd0);

    // R4 receive full drop
    for (int i = 0; i < 9; i++) rxpush(32'hB0 + i);
    peek(3'd1, v); chk("R4 rx full", v & 32'hF, 32'h8);
    chk("R4 no room", {31'd0, eng_rx_room}, 32'd0);

    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom % 100;
      reg_addr  = 3'($urandom % 6);
      reg_wdata = $urandom;
      reg_we    = (r < 40);
      reg_re    = (r >= 40 && r < 60);
      if (reg_addr == 3'd0 && ($urandom % 8) != 0) reg_wdata[1:0] = 2'b00;
      eng_tx_pop  = ($urandom % 3) == 0;
      eng_rx_push = ($urandom % 3) == 0;
      eng_rx_data = $urandom;
      ev_nack     = ($urandom % 20) == 0;
      ev_arb_lost = ($urandom % 20) == 0;
      ev_pkt_done = ($urandom % 20) == 0;
      ev_all_done = ($urandom % 20) == 0;
      step();
    end
    idle();
    step();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule